// File: doc/BRIEF.md
# Sloppy Pseudo-Mersenne Modular Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and reduces the product against the working modulus 2^WIDTH − `FOLD_K`. With the default values, that is 128-bit operands and the modulus 2^128 − 3. That value is a redundant multiple of a smaller prime, so any residue congruent to the product is useful downstream. The reduction is a pair of constant folds. Each fold uses the identity 2^WIDTH ≡ `FOLD_K` and replaces a value xH·2^WIDTH + xL with xL + `FOLD_K`·xH. No comparison or subtraction follows, so the result may sit at or above the modulus.

The product is built one limb pair at a time. Each operand is cut into `LIMB_W`-bit limbs (16 bits by default). A single `LIMB_W`×`LIMB_W` multiplier forms one partial product per cycle, and each partial product is added at its weight into a double-width accumulator. One cycle then does the first fold and one more does the second. After two folds the value can reach 2^WIDTH + 2·`FOLD_K` − 1, which needs one bit more than the result port. That extra bit is brought out as a flag rather than corrected; it is almost never set.

Operands enter through a valid/ready handshake. The block holds one operation at a time, and the result is held until the consumer takes it.

Top module: `modmul_sloppy`

## Requirements
- R1: While and after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Operands are captured on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle, `in_ready` stays 0 until the result has been taken.
- R3: The reported value is congruent to `in_a`·`in_b` modulo 2^WIDTH − FOLD_K. This holds directly when `out_ovf` is 0, and after adding FOLD_K when `out_ovf` is 1.
- R4: `out_res` is exactly the low WIDTH bits of fold(fold(a·b)), where fold(x) = (x mod 2^WIDTH) + FOLD_K·⌊x / 2^WIDTH⌋. No final subtraction is done, so a value in [2^WIDTH − FOLD_K, 2^WIDTH − 1] is returned unreduced. For example, a = 2^WIDTH − 1 and b = 1 give 2^WIDTH − 1.
- R5: `out_ovf` equals bit WIDTH of the second fold (its carry out of bit WIDTH−1). When it is 1, `out_res` is below 2·FOLD_K. For example, two all-ones operands give `out_res` = 1 with `out_ovf` = 1.
- R6: `out_valid` rises (WIDTH/LIMB_W)² + 2 clock edges after the edge that captured the operands.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_res` and `out_ovf` do not change and `in_ready` stays 0. The edge with `out_ready` = 1 ends the result: `out_valid` drops and `in_ready` rises.
- R8: Changes on `in_a`, `in_b` and `in_valid` while an operation is in progress have no effect on its result, and no second result appears.
- R9: A zero operand gives `out_res` = 0 with `out_ovf` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on `in_a`/`in_b` are offered |
| in_ready | output | 1 | Block is idle and will take operands |
| in_a | input | WIDTH | Multiplicand |
| in_b | input | WIDTH | Multiplier |
| out_valid | output | 1 | Result is held on `out_res`/`out_ovf` |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | WIDTH | Low WIDTH bits of the twice-folded product |
| out_ovf | output | 1 | Second fold carried past bit WIDTH−1 |

## Verification
The rare case is the one where the carry out of the second fold and the wrap of the low part land in the same result: a tiny `out_res` appears together with a raised `out_ovf`. All-ones operands provoke it at full width. An 8-bit instance is also searched exhaustively for every operand pair that carries, and those pairs are applied. Each result is judged against a twice-folded product computed arithmetically in the bench, including the bound on `out_res` and the congruence after adding FOLD_K. The common no-carry case, including unreduced values just under 2^WIDTH, is judged against the same computation.

// File: rtl/modmul_sloppy_pkg.sv
package modmul_sloppy_pkg;

    typedef enum logic [2:0] {
        MM_IDLE  = 3'd0,
        MM_MUL   = 3'd1,
        MM_FOLDA = 3'd2,
        MM_FOLDB = 3'd3,
        MM_DONE  = 3'd4
    } mm_state_e;

endpackage

// File: rtl/mmul_limb_mult.sv
// One LW x LW -> 2*LW unsigned multiplier, the only multiplier in the block.
module mmul_limb_mult #(
    parameter int LW = 16
) (
    input  logic [LW-1:0]   x,
    input  logic [LW-1:0]   y,
    output logic [2*LW-1:0] p
);
    assign p = {{LW{1'b0}}, x} * {{LW{1'b0}}, y};
endmodule

// File: rtl/mmul_limb_pick.sv
// Selects limb number sel from a W-bit word.
module mmul_limb_pick #(
    parameter int W  = 128,
    parameter int LW = 16,
    parameter int IW = 3
) (
    input  logic [W-1:0]  word,
    input  logic [IW-1:0] sel,
    output logic [LW-1:0] limb
);
    assign limb = word[32'(sel) * LW +: LW];
endmodule

// File: rtl/mmul_fold.sv
// One fold: x = hi*2^W + lo  ->  lo + K*hi  (2^W == K mod 2^W - K).
module mmul_fold #(
    parameter int IN_W  = 256,
    parameter int W     = 128,
    parameter int OUT_W = 130,
    parameter int K     = 3
) (
    input  logic [IN_W-1:0]  x,
    output logic [OUT_W-1:0] y
);
    localparam int HW = IN_W - W;

    logic [W-1:0]  lo;
    logic [HW-1:0] hi;

    assign lo = x[W-1:0];
    assign hi = x[IN_W-1:W];
    assign y  = OUT_W'(lo) + OUT_W'(hi) * OUT_W'(K);
endmodule

// File: rtl/modmul_sloppy.sv
module modmul_sloppy
    import modmul_sloppy_pkg::*;
#(
    parameter int WIDTH  = 128,
    parameter int LIMB_W = 16,
    parameter int FOLD_K = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_res,
    output logic             out_ovf
);
    localparam int N_LIMB = WIDTH / LIMB_W;
    localparam int N_PP   = N_LIMB * N_LIMB;
    localparam int IW     = (N_LIMB > 1) ? $clog2(N_LIMB) : 1;
    localparam int KW     = $clog2(FOLD_K + 1);
    localparam int ACC_W  = 2 * WIDTH;
    localparam int Y_W    = WIDTH + KW;
    localparam int Z_W    = WIDTH + 1;
    localparam logic [IW-1:0] LAST = IW'(N_LIMB - 1);

    typedef struct packed {
        mm_state_e        st;
        logic [WIDTH-1:0] a;
        logic [WIDTH-1:0] b;
        logic [ACC_W-1:0] acc;
        logic [IW-1:0]    ia;
        logic [IW-1:0]    ib;
        logic [Y_W-1:0]   y;
        logic [WIDTH-1:0] res;
        logic             ovf;
    } mm_regs_t;

    mm_regs_t q, d;

    // limb selection for both operands
    logic [LIMB_W-1:0] limb [2];
    logic [2*LIMB_W-1:0] pp;
    logic [ACC_W-1:0]    pp_placed;
    logic [Y_W-1:0]      fold_a_out;
    logic [Z_W-1:0]      fold_b_out;

    for (genvar op = 0; op < 2; op++) begin : g_pick
        mmul_limb_pick #(.W(WIDTH), .LW(LIMB_W), .IW(IW)) u_pick (
            .word (op == 0 ? q.a  : q.b),
            .sel  (op == 0 ? q.ia : q.ib),
            .limb (limb[op])
        );
    end

    mmul_limb_mult #(.LW(LIMB_W)) u_mult (
        .x (limb[0]),
        .y (limb[1]),
        .p (pp)
    );

    mmul_fold #(.IN_W(ACC_W), .W(WIDTH), .OUT_W(Y_W), .K(FOLD_K)) u_fold_a (
        .x (q.acc),
        .y (fold_a_out)
    );

    mmul_fold #(.IN_W(Y_W), .W(WIDTH), .OUT_W(Z_W), .K(FOLD_K)) u_fold_b (
        .x (q.y),
        .y (fold_b_out)
    );

    always_comb begin
        d = q;
        pp_placed = {{(ACC_W - 2*LIMB_W){1'b0}}, pp}
                    << (LIMB_W * (32'(q.ia) + 32'(q.ib)));
        case (q.st)
            MM_IDLE: begin
                if (in_valid) begin
                    d.a   = in_a;
                    d.b   = in_b;
                    d.acc = '0;
                    d.ia  = '0;
                    d.ib  = '0;
                    d.st  = MM_MUL;
                end
            end
            MM_MUL: begin
                d.acc = q.acc + pp_placed;
                if (q.ia == LAST) begin
                    d.ia = '0;
                    if (q.ib == LAST) begin
                        d.st = MM_FOLDA;
                    end else begin
                        d.ib = q.ib + IW'(1);
                    end
                end else begin
                    d.ia = q.ia + IW'(1);
                end
            end
            MM_FOLDA: begin
                d.y  = fold_a_out;
                d.st = MM_FOLDB;
            end
            MM_FOLDB: begin
                d.res = fold_b_out[WIDTH-1:0];
                d.ovf = fold_b_out[WIDTH];
                d.st  = MM_DONE;
            end
            MM_DONE: begin
                if (out_ready) begin
                    d.st = MM_IDLE;
                end
            end
            default: d.st = MM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign in_ready  = (q.st == MM_IDLE);
    assign out_valid = (q.st == MM_DONE);
    assign out_res   = q.res;
    assign out_ovf   = q.ovf;

    initial begin
        if (WIDTH % LIMB_W != 0 || N_LIMB < 2) begin
            $error("WIDTH must be a multiple of LIMB_W with at least two limbs");
        end
    end

endmodule

// File: rtl/modmul_sloppy_chk.sv
module modmul_sloppy_chk #(
    parameter int WIDTH  = 128,
    parameter int LIMB_W = 16,
    parameter int FOLD_K = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [WIDTH-1:0] out_res,
    input logic             out_ovf
);
    localparam int N_LIMB = WIDTH / LIMB_W;
    localparam int N_PP   = N_LIMB * N_LIMB;

    logic [31:0] lat_q;
    logic        busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q  <= '0;
            busy_q <= 1'b0;
        end else if (in_valid && in_ready) begin
            lat_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            lat_q <= lat_q + 32'd1;
            if (out_valid && out_ready) busy_q <= 1'b0;
        end
    end

    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R2

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (busy_q && lat_q == 32'(N_PP + 2))); // R6

    AST_OVF_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ovf) |-> (out_res < WIDTH'(2 * FOLD_K))); // R5

    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid); // R7

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> ($stable(out_res) && $stable(out_ovf))); // R7

    AST_VALID_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R7

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (!out_valid && in_ready)); // R7

endmodule

bind modmul_sloppy modmul_sloppy_chk #(
    .WIDTH  (WIDTH),
    .LIMB_W (LIMB_W),
    .FOLD_K (FOLD_K)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_res   (out_res),
    .out_ovf   (out_ovf)
);

// File: tb/modmul_sloppy_bench.sv
`timescale 1ns/1ps
module modmul_sloppy_bench;
    localparam int BW   = 128;
    localparam int BLW  = 16;
    localparam int SW   = 8;
    localparam int SLW  = 4;
    localparam int BLAT = (BW / BLW) * (BW / BLW) + 3;  // negedges from drive to out_valid
    localparam int SLAT = (SW / SLW) * (SW / SLW) + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // full-width instance
    logic          b_in_valid = 1'b0, b_in_ready, b_out_valid, b_out_ready = 1'b0, b_ovf;
    logic [BW-1:0] b_a = '0, b_b = '0, b_res;
    // small instance for exhaustive search
    logic          s_in_valid = 1'b0, s_in_ready, s_out_valid, s_out_ready = 1'b1, s_ovf;
    logic [SW-1:0] s_a = '0, s_b = '0, s_res;

    modmul_sloppy u_modmul_sloppy (
        .clk(clk), .rst_n(rst_n), .in_valid(b_in_valid), .in_ready(b_in_ready),
        .in_a(b_a), .in_b(b_b), .out_valid(b_out_valid), .out_ready(b_out_ready),
        .out_res(b_res), .out_ovf(b_ovf));

    modmul_sloppy #(.WIDTH(SW), .LIMB_W(SLW), .FOLD_K(3)) u_modmul_sloppy_small (
        .clk(clk), .rst_n(rst_n), .in_valid(s_in_valid), .in_ready(s_in_ready),
        .in_a(s_a), .in_b(s_b), .out_valid(s_out_valid), .out_ready(s_out_ready),
        .out_res(s_res), .out_ovf(s_ovf));

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [259:0] act,
                       input logic [259:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // twice-folded product per R4, in a wide container
    function automatic logic [259:0] spec_fold2(input logic [259:0] a, input logic [259:0] b,
                                               input int w);
        logic [259:0] mask, x, y;
        mask = (260'd1 << w) - 260'd1;
        x = a * b;
        y = (x & mask) + 260'd3 * (x >> w);
        return (y & mask) + 260'd3 * (y >> w);
    endfunction

    function automatic logic [259:0] modp(input logic [259:0] v, input int w);
        return v % ((260'd1 << w) - 260'd3);
    endfunction

    task automatic op_big(input logic [BW-1:0] a, input logic [BW-1:0] b,
                          input int hold, input bit noise, input string tag);
        logic [259:0] z, exp_res, got;
        int n;
        z = spec_fold2(260'(a), 260'(b), BW);
        exp_res = z & ((260'd1 << BW) - 260'd1);
        @(negedge clk);
        b_in_valid = 1'b1; b_a = a; b_b = b;
        @(negedge clk);
        chk(b_in_ready == 1'b0, {"R2 busy ", tag}, 260'(b_in_ready), 260'd0);
        if (noise) begin   // R8: foreign request during busy
            b_a = ~a; b_b = a ^ b;
        end else begin
            b_in_valid = 1'b0;
        end
        n = 1;
        while (!b_out_valid && n < 1000) begin
            @(negedge clk);
            n++;
            if (noise && n == 5) b_a = b_a + 1;
        end
        b_in_valid = 1'b0;
        chk(n == BLAT, {"R6 latency ", tag}, 260'(n), 260'(BLAT));
        chk(260'(b_res) == exp_res, {"R4 result ", tag}, 260'(b_res), exp_res);
        chk(b_ovf == z[BW], {"R5 flag ", tag}, 260'(b_ovf), 260'(z[BW]));
        got = 260'(b_res) + (b_ovf ? 260'd3 : 260'd0);
        chk(modp(got, BW) == modp(260'(a) * 260'(b), BW), {"R3 congruence ", tag},
            modp(got, BW), modp(260'(a) * 260'(b), BW));
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(b_out_valid && !b_in_ready && 260'(b_res) == exp_res,
                {"R7 hold ", tag}, 260'(b_res), exp_res);
        end
        b_out_ready = 1'b1;
        @(negedge clk);
        b_out_ready = 1'b0;
        chk(!b_out_valid && b_in_ready, {"R7 release ", tag},
            260'({b_out_valid, b_in_ready}), 260'd1);
        @(negedge clk);
        chk(!b_out_valid, {"R8 no extra result ", tag}, 260'(b_out_valid), 260'd0);
    endtask

    task automatic op_small(input logic [SW-1:0] a, input logic [SW-1:0] b);
        logic [259:0] z;
        int n;
        z = spec_fold2(260'(a), 260'(b), SW);
        s_in_valid = 1'b1; s_a = a; s_b = b;
        @(negedge clk);
        s_in_valid = 1'b0;
        n = 1;
        while (!s_out_valid && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(n == SLAT, "R6 small latency", 260'(n), 260'(SLAT));
        chk(260'(s_res) == (z & 260'hFF) && s_ovf == z[SW], "R4 R5 small result",
            260'({s_ovf, s_res}), z & 260'h1FF);
        chk(modp(260'(s_res) + (s_ovf ? 260'd3 : 260'd0), SW) == modp(260'(a) * 260'(b), SW),
            "R3 small congruence", 260'({s_ovf, s_res}), modp(260'(a) * 260'(b), SW));
        @(negedge clk);   // out_ready held high: back to idle
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL R6 watchdog act=hung exp=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    logic [SW-1:0] fa [64];
    logic [SW-1:0] fb [64];
    int nf;
    logic [SW-1:0] blist [16];
    logic [BW-1:0] ones;

    initial begin
        ones = '1;
        repeat (3) @(negedge clk);
        chk(!b_out_valid && b_in_ready && !s_out_valid && s_in_ready, "R1 in reset",
            260'({b_out_valid, b_in_ready}), 260'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!b_out_valid && b_in_ready, "R1 after reset",
            260'({b_out_valid, b_in_ready}), 260'd1);

        // directed full-width cases
        op_big('0, ones, 0, 1'b0, "R9 zero a");
        chk(b_res == '0 && !b_ovf, "R9 zero result", 260'(b_res), 260'd0);
        op_big(128'h1234_5678_9abc_def0_0fed_cba9_8765_4321, '0, 1, 1'b0, "R9 zero b");
        op_big(ones, 128'd1, 2, 1'b0, "R4 unreduced all-ones");
        chk(b_res == ones && !b_ovf, "R4 unreduced kept", 260'(b_res), 260'(ones));
        op_big(ones - 128'd2, 128'd5, 0, 1'b0, "R4 modulus times five");
        chk(b_res == ones - 128'd2, "R4 modulus left unreduced", 260'(b_res), 260'(ones - 128'd2));
        op_big(ones, ones, 3, 1'b0, "R5 all-ones squared");
        chk(b_ovf && b_res == 128'd1, "R5 carry case", 260'({b_ovf, b_res}),
            (260'd1 << 128) | 260'd1);
        op_big(128'd1 << 127, 128'd2, 0, 1'b1, "R8 noise top bit");
        for (int i = 0; i < 40; i++) begin
            op_big({$urandom, $urandom, $urandom, $urandom},
                   {$urandom, $urandom, $urandom, $urandom},
                   i % 3, (i % 2) == 1, "R3 random");
        end

        // small instance: find every carrying pair by arithmetic
        nf = 0;
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                logic [259:0] z;
                z = spec_fold2(260'(a), 260'(b), SW);
                if (z[SW] && nf < 64) begin
                    fa[nf] = 8'(a); fb[nf] = 8'(b); nf++;
                end
            end
        end
        chk(nf > 0, "R5 carrying pairs exist", 260'(nf), 260'd1);
        @(negedge clk);
        for (int i = 0; i < nf; i++) begin
            op_small(fa[i], fb[i]);
            chk(s_ovf && s_res < 8'd6, "R5 small carry bound", 260'({s_ovf, s_res}), 260'h100);
        end
        blist = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd5, 8'd127, 8'd128, 8'd129,
                  8'd200, 8'd250, 8'd251, 8'd252, 8'd253, 8'd254, 8'd255, 8'd77};
        for (int a = 0; a < 256; a++) begin
            for (int j = 0; j < 16; j++) begin
                op_small(8'(a), blist[j]);
            end
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule